// File: doc/BRIEF.md
# Byte-Addressed Serial EEPROM Target

This block is a two-wire serial bus target that fronts a 256-byte storage array. Access to the array goes through one 8-bit pointer. SCL and SDA arrive as plain inputs. The only thing the block drives is a pull-low enable for SDA, so it can sit on an open-drain bus. A 3-bit strap picks one of eight bus addresses, which lets up to eight copies share one bus.

A write transaction works as follows. The first byte after the address is taken as the new pointer value. Every byte after that is stored at the pointer, and the pointer then steps forward. A read transaction streams bytes out from the pointer, and the pointer steps forward after each byte. If a write transaction carries only the offset and is followed by a repeated START and a read address, the result is a random read. Reset reloads the whole array from a flat preload image and clears the pointer to zero. A sticky flag records that a transaction has reached its data phase.

Top module: `smbus_eeprom`

## Requirements
- R1: The target ACKs only the 7-bit address 0x50 + `dev_idx_i` (binary 1010 followed by the index). It leaves SDA released for every other address and ignores the rest of that transaction.
- R2: In a write, the first data byte after the address is loaded into the pointer and is not stored. That byte is ACKed, and a later read without a new offset starts at this value.
- R3: Each further data byte in a write is ACKed and stored at the pointer, and the pointer then increments.
- R4: The pointer wraps from 255 to 0, both on writes and on reads.
- R5: In a read, each byte is the array location at the pointer, sent MSB first. The pointer increments after each byte. The target keeps sending while the controller ACKs. After a controller NACK it leaves SDA released.
- R6: A repeated START after an offset-only write, followed by the read address, reads from the new offset.
- R7: Reset reloads all 256 bytes from `preload_i`, where byte n sits at bits [8n+7:8n], and sets the pointer to 0.
- R8: `accessed_o` is 0 after reset. A matching transaction that reaches its data phase sets it, and it stays set until the next reset. A transaction that carries only an address does not set it.
- R9: The target starts pulling SDA low only while SCL is low.
- R10: After a STOP, bits clocked without a new START are ignored: no ACK, no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| dev_idx_i | input | 3 | Address strap added to base 0x50 |
| preload_i | input | 2048 | Initial array image, byte n at [8n+7:8n] |
| accessed_o | output | 1 | Sticky flag: a data phase has occurred |

## Verification
The store of a write byte and the pointer advance happen in the same clock cycle. At the top of the array, the wrap also falls in that same cycle. To provoke this, a write burst starts at offset 0xFD and runs across 0xFF into 0x00. A random read that starts two bytes below the written bytes and also crosses the boundary then judges the result: it must return the untouched neighbours and the new bytes at the expected addresses. The bench also reads one full sweep of 257 bytes, which makes the read-side increment wrap in the same cycle as a byte load.

// File: rtl/smbus_eeprom_pkg.sv
package smbus_eeprom_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  // bus conditions: SDA edge while SCL stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [(1<<ADDR_W)*DATA_W-1:0]    preload_i,
  input  logic                             we_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic                             ptr_load_i,
  input  logic [ADDR_W-1:0]                ptr_val_i,
  input  logic                             ptr_inc_i,
  output logic [ADDR_W-1:0]                ptr_o,
  output logic [DATA_W-1:0]                rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= preload_i[i*DATA_W +: DATA_W];
    end else if (we_i) begin
      mem_q[ptr_q] <= wdata_i;
    end
  end

  // natural width rollover gives the modulo-depth wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ptr_q <= '0;
    else if (ptr_load_i) ptr_q <= ptr_val_i;
    else if (ptr_inc_i)  ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o   = ptr_q;
  assign rdata_o = mem_q[ptr_q];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import smbus_eeprom_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         IDX_W     = 3,
  parameter logic [6:0] BASE_ADDR = 7'h50
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sda_s_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic [IDX_W-1:0]   dev_idx_i,
  input  logic [BYTE_W-1:0]  rdata_i,
  output logic               sda_oe_o,
  output logic               we_o,
  output logic [BYTE_W-1:0]  wdata_o,
  output logic               ptr_load_o,
  output logic [ADDR_W-1:0]  ptr_val_o,
  output logic               ptr_inc_o,
  output logic               accessed_o,
  output tgt_state_e         state_o
);
  tgt_state_e        state_q;
  logic [3:0]        bitcnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              first_q, rnw_q, mack_q, oe_q, acc_q;
  logic [6:0]        tgt_addr;
  logic              addr_hit, byte_in_done, rd_load;

  assign tgt_addr     = BASE_ADDR + 7'(dev_idx_i);
  assign addr_hit     = (shreg_q[7:1] == tgt_addr);
  assign byte_in_done = (state_q == ST_WR) && scl_fall_i && (bitcnt_q == 4'd8);
  assign rd_load      = scl_fall_i &&
                        (((state_q == ST_ADDR_ACK) && rnw_q) ||
                         ((state_q == ST_RD_ACK) && mack_q));

  assign we_o       = byte_in_done && !first_q;
  assign ptr_load_o = byte_in_done && first_q;
  assign ptr_inc_o  = we_o || rd_load;
  assign wdata_o    = shreg_q;
  assign ptr_val_o  = shreg_q[ADDR_W-1:0];
  assign sda_oe_o   = oe_q;
  assign accessed_o = acc_q;
  assign state_o    = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      first_q  <= 1'b0;
      rnw_q    <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
      acc_q    <= 1'b0;
    end else if (start_i) begin
      state_q  <= ST_ADDR;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      oe_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise_i && bitcnt_q < 4'd8) begin
            shreg_q  <= {shreg_q[6:0], sda_s_i};
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (scl_fall_i && bitcnt_q == 4'd8) begin
            if (state_q == ST_WR) begin
              first_q <= 1'b0;
              acc_q   <= 1'b1;
              oe_q    <= 1'b1;
              state_q <= ST_WR_ACK;
            end else if (addr_hit) begin
              oe_q    <= 1'b1;
              rnw_q   <= shreg_q[0];
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            bitcnt_q <= '0;
            if (rnw_q) begin
              shreg_q <= rdata_i;
              oe_q    <= ~rdata_i[7];
              acc_q   <= 1'b1;
              state_q <= ST_RD;
            end else begin
              oe_q    <= 1'b0;
              first_q <= 1'b1;
              state_q <= ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) begin
            oe_q     <= 1'b0;
            bitcnt_q <= '0;
            state_q  <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise_i && bitcnt_q < 4'd8) begin
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (bitcnt_q == 4'd8) begin
              oe_q    <= 1'b0;
              state_q <= ST_RD_ACK;
            end else begin
              shreg_q <= {shreg_q[6:0], 1'b0};
              oe_q    <= ~shreg_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_s_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              shreg_q  <= rdata_i;
              oe_q     <= ~rdata_i[7];
              bitcnt_q <= '0;
              state_q  <= ST_RD;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smbus_eeprom.sv
module smbus_eeprom
  import smbus_eeprom_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         IDX_W       = 3,
  parameter logic [6:0] BASE_ADDR   = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                scl_i,
  input  logic                                sda_i,
  output logic                                sda_oe_o,
  input  logic [IDX_W-1:0]                    dev_idx_i,
  input  logic [(1<<ADDR_W)*BYTE_W-1:0]       preload_i,
  output logic                                accessed_o
);
  logic scl_s, sda_s, start, stop, scl_rise, scl_fall;
  logic we, ptr_load, ptr_inc;
  logic [BYTE_W-1:0] wdata, rdata;
  logic [ADDR_W-1:0] ptr, ptr_val;
  tgt_state_e state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start), .stop_o(stop),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  i2c_tgt_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)) i_fsm (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .start_i(start), .stop_i(stop),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .dev_idx_i, .rdata_i(rdata),
    .sda_oe_o, .we_o(we), .wdata_o(wdata), .ptr_load_o(ptr_load),
    .ptr_val_o(ptr_val), .ptr_inc_o(ptr_inc), .accessed_o, .state_o(state)
  );

  eeprom_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) i_store (
    .clk_i, .rst_ni, .preload_i, .we_i(we), .wdata_i(wdata),
    .ptr_load_i(ptr_load), .ptr_val_i(ptr_val), .ptr_inc_i(ptr_inc),
    .ptr_o(ptr), .rdata_o(rdata)
  );
endmodule

// File: rtl/smbus_eeprom_chk.sv
module smbus_eeprom_chk
  import smbus_eeprom_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s_i,
  input logic          sda_oe_i,
  input logic          accessed_i,
  input logic          we_i,
  input logic          ptr_load_i,
  input logic          ptr_inc_i,
  input logic [AW-1:0] ptr_i,
  input logic [AW-1:0] ptr_val_i,
  input tgt_state_e    state_i
);
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accessed_i |=> accessed_i);

  a_r8_store_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> accessed_i);

  a_r9_pull_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_s_i);

  a_r2_offset_not_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_load_i |-> !we_i);

  a_r2_offset_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_load_i |=> ptr_i == $past(ptr_val_i));

  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_inc_i |=> ptr_i == AW'($past(ptr_i) + 1'b1));

  a_r5_release_in_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RD_ACK) |-> !sda_oe_i);
endmodule

bind smbus_eeprom smbus_eeprom_chk #(.AW(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_oe_i(sda_oe_o),
  .accessed_i(accessed_o), .we_i(we), .ptr_load_i(ptr_load),
  .ptr_inc_i(ptr_inc), .ptr_i(ptr), .ptr_val_i(ptr_val), .state_i(state)
);

// File: tb/test_smbus_eeprom.sv
module test_smbus_eeprom;
  localparam int Q = 5;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_scl = 1'b1;
  logic tb_sda_oe = 1'b0;
  logic [2:0] dev_idx = 3'd5;
  logic [DEPTH*8-1:0] img;
  logic sda_oe, accessed, sda_line;
  int nchk = 0, nfail = 0, viol = 0;
  int exp_mem [DEPTH];
  logic oe_prev = 1'b0;

  assign sda_line = ~(tb_sda_oe | sda_oe);

  always #10 clk = ~clk;

  smbus_eeprom i_smbus_eeprom (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(tb_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .dev_idx_i(dev_idx), .preload_i(img), .accessed_o(accessed)
  );

  // R9 monitor: a new pull-low must not begin while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && tb_scl) viol++;
    oe_prev = sda_oe;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    tb_sda_oe = 1'b0; wq(Q);
    tb_scl = 1'b1;    wq(Q);
    tb_sda_oe = 1'b1; wq(Q);
    tb_scl = 1'b0;    wq(Q);
  endtask

  task automatic bus_stop();
    tb_sda_oe = 1'b1; wq(Q);
    tb_scl = 1'b1;    wq(Q);
    tb_sda_oe = 1'b0; wq(Q);
  endtask

  task automatic send_bit(input bit b);
    tb_sda_oe = ~b; wq(Q);
    tb_scl = 1'b1;  wq(2*Q);
    tb_scl = 1'b0;  wq(Q);
  endtask

  task automatic recv_bit(output bit b);
    tb_sda_oe = 1'b0; wq(Q);
    tb_scl = 1'b1;    wq(Q);
    b = sda_line;     wq(Q);
    tb_scl = 1'b0;    wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~give_ack);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    logic [7:0] wd [4];
    wd[0] = 8'hC3; wd[1] = 8'h3C; wd[2] = 8'hA5; wd[3] = 8'h5A;
    for (int n = 0; n < DEPTH; n++) begin
      img[n*8 +: 8] = 8'((n * 37 + 11) & 255);
      exp_mem[n] = (n * 37 + 11) & 255;
    end
    wq(5);
    rst_n = 1'b1;
    wq(5);
    check("R8 accessed after reset", int'(accessed), 0);
    check("R5 idle release", int'(sda_oe), 0);

    // R1: full address sweep with strap 5
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      bus_stop();
      check($sformatf("R1 ack addr %0h", a), int'(ack), int'(a == 8'h55));
    end
    check("R8 address-only leaves clear", int'(accessed), 0);

    // R1: every strap value
    for (int i = 0; i < 8; i++) begin
      dev_idx = 3'(i);
      bus_start();
      send_byte({7'(8'h50 + i), 1'b0}, ack);
      bus_stop();
      check($sformatf("R1 strap %0d own", i), int'(ack), 1);
      bus_start();
      send_byte({7'(8'h50 + ((i + 1) % 8)), 1'b0}, ack);
      bus_stop();
      check($sformatf("R1 strap %0d other", i), int'(ack), 0);
    end
    dev_idx = 3'd5;

    // R7/R5/R4: read 257 bytes from the reset pointer
    bus_start();
    send_byte({7'h55, 1'b1}, ack);
    check("R5 read addr ack", int'(ack), 1);
    for (int k = 0; k <= DEPTH; k++) begin
      recv_byte(k < DEPTH, d);
      if (k < DEPTH) check($sformatf("R7 R5 byte %0d", k), int'(d), exp_mem[k]);
      else           check("R4 read wrap", int'(d), exp_mem[0]);
    end
    check("R5 released after nack", int'(sda_oe), 0);
    bus_stop();
    check("R8 set by read", int'(accessed), 1);

    // R2/R3/R4: write burst across the top
    bus_start();
    send_byte({7'h55, 1'b0}, ack);
    send_byte(8'hFD, ack);
    check("R2 offset ack", int'(ack), 1);
    for (int j = 0; j < 4; j++) begin
      send_byte(wd[j], ack);
      check($sformatf("R3 data ack %0d", j), int'(ack), 1);
      exp_mem[(8'hFD + j) & 255] = int'(wd[j]);
    end
    bus_stop();

    // R10: stray byte without START
    send_byte(8'h99, ack);
    check("R10 no ack after stop", int'(ack), 0);
    bus_stop();

    // R6/R4: random read across the boundary
    bus_start();
    send_byte({7'h55, 1'b0}, ack);
    send_byte(8'hFB, ack);
    bus_start();
    send_byte({7'h55, 1'b1}, ack);
    check("R6 read addr ack", int'(ack), 1);
    for (int j = 0; j < 8; j++) begin
      recv_byte(j < 7, d);
      check($sformatf("R6 R4 byte %0d", j), int'(d), exp_mem[(8'hFB + j) & 255]);
    end
    bus_stop();

    // R2: offset-only write then current-address reads
    bus_start();
    send_byte({7'h55, 1'b0}, ack);
    send_byte(8'h80, ack);
    bus_stop();
    bus_start();
    send_byte({7'h55, 1'b1}, ack);
    recv_byte(1'b0, d);
    bus_stop();
    check("R2 pointer from offset", int'(d), exp_mem[8'h80]);
    bus_start();
    send_byte({7'h55, 1'b1}, ack);
    recv_byte(1'b0, d);
    bus_stop();
    check("R5 pointer advanced", int'(d), exp_mem[8'h81]);

    // R7: reset restores image and pointer
    rst_n = 1'b0; wq(3);
    rst_n = 1'b1; wq(5);
    check("R8 cleared by reset", int'(accessed), 0);
    for (int n = 0; n < DEPTH; n++) exp_mem[n] = (n * 37 + 11) & 255;
    bus_start();
    send_byte({7'h55, 1'b1}, ack);
    for (int k = 0; k < DEPTH; k++) begin
      recv_byte(k < DEPTH - 1, d);
      check($sformatf("R7 reload byte %0d", k), int'(d), exp_mem[k]);
    end
    bus_stop();

    check("R9 drive start while SCL low", viol, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule